// File: doc/BRIEF.md
# Fault-Tolerant Unary-Stream Five-Tap FIR Filter

This block filters a stream of 8-bit unsigned samples with five 8-bit unsigned coefficients. It computes each tap product as a redundant unary bit stream rather than as a binary word. For every pair of bits (sample bit i, coefficient bit j), the AND of the two bits is copied eight times into the stream of column i+j. All five taps then contribute their streams of the same weight to one merged column, and the merge alone performs the exact sum. Each of the fifteen merged columns also carries four constant one-bits, and one set of these serves all five taps. Because of this redundancy, each column still decodes correctly with up to three flipped stream bits.

A population counter decodes each merged column as the floor of its ones count divided by eight. A weighted adder then combines the fifteen column values into the binary filter result. A 5-deep delay line of samples advances on every valid input. The result is registered, so it appears one cycle after the input. It is flagged valid only once five samples have been taken in since reset. The testbench drives a flip-mask input to upset stream bits, and so checks the fault tolerance. In normal use this input is tied to zero.

Top module: `stream_fir`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `out_valid` is 0 and `y` is 0. Reset also clears all coefficients and the sample history.
- R2: A cycle with `coef_we` high and `coef_addr` of 0 to 4 loads `coef_data` into the coefficient of the tap at that address. Address 0 weights the newest sample and address 4 the oldest. Writes to addresses 5 to 7 change no coefficient.
- R3: On the clock edge where `in_valid` is high, `y` takes the value sum over k=0..4 of c_k * x[n-k]. Here x[n] is the sample presented on that edge, and x[n-k] is the sample k valid inputs earlier.
- R4: `out_valid` is high for exactly the one cycle after each valid input, from the fifth valid input after reset onward. It stays 0 for the first four valid inputs.
- R5: Cycles with `in_valid` low leave `y` unchanged, and the cycle after each such cycle has `out_valid` low. This holds whatever `fault_mask` carries in those cycles.
- R6: Setting a bit of `fault_mask` inverts one stream bit. Data bit (tap k, sample bit i, coefficient bit j, copy r) sits at index ((k*8+i)*8+j)*8+r and belongs to column i+j. Any pattern with at most three set bits per column, flipping ones to zeros or zeros to ones, leaves `y` exactly equal to the fault-free value.
- R7: Bias bit b (0 to 3) of column c sits at `fault_mask` index 2560+4*c+b. Flips of bias bits count toward the same three-per-column bound and leave `y` exact.
- R8: The result never overflows. With all coefficients and five consecutive samples at 255, `y` equals 325125 and is never above that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 3 | Tap index of the coefficient write |
| coef_data | input | 8 | Coefficient value to write |
| in_valid | input | 1 | Sample strobe; advances the delay line |
| x_in | input | 8 | Unsigned input sample |
| fault_mask | input | 2620 | Per-bit inversion of the unary streams (tie to zero in use) |
| out_valid | output | 1 | Result strobe, one cycle after a valid input once five samples are in |
| y | output | 19 | Unsigned filter result |

## Verification
The filtered result and its strobe register on the same rising edge that takes the sample, so both are due exactly one edge after `in_valid`. A coefficient write takes effect on the edge that carries it. The bench drives every input on the falling edge and samples `y` and `out_valid` on the next falling edge, which falls half a period after the edge that must update them. In idle stretches it reads the outputs after each edge and confirms that nothing moved. The fault masks are presented together with the sample they upset, because the streams they flip exist only combinationally in that cycle.

// File: rtl/stream_fir.sv
module stream_fir #(
  parameter int W    = 8,
  parameter int TAPS = 5,
  parameter int REP  = 8,
  localparam int AW    = $clog2(TAPS),
  localparam int COLS  = 2*W - 1,
  localparam int BIAS  = REP/2,
  localparam int DBITS = TAPS*W*W*REP,
  localparam int FLAT  = DBITS + COLS*BIAS,
  localparam int YW    = 2*W + $clog2(TAPS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            coef_we,
  input  logic [AW-1:0]   coef_addr,
  input  logic [W-1:0]    coef_data,
  input  logic            in_valid,
  input  logic [W-1:0]    x_in,
  input  logic [FLAT-1:0] fault_mask,
  output logic            out_valid,
  output logic [YW-1:0]   y
);
  localparam int CW = $clog2(TAPS*W*REP + BIAS + 1);
  localparam int FW = $clog2(TAPS);

  logic [W-1:0]      coef [TAPS];
  logic [W-1:0]      dly  [TAPS-1];
  logic [W-1:0]      win  [TAPS];
  logic [TAPS*W-1:0] coef_flat;
  logic [FLAT-1:0]   strm;
  logic [COLS*CW-1:0] ccnt;
  logic [YW-1:0]     ysum;
  logic [FW-1:0]     fill;
  logic              full;

  wire addr_ok = {1'b0, coef_addr} < (AW+1)'(TAPS);
  assign full  = (fill == FW'(TAPS-1));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < TAPS; k++) coef[k] <= '0;
    end else if (coef_we && addr_ok) begin
      coef[coef_addr] <= coef_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < TAPS-1; k++) dly[k] <= '0;
    end else if (in_valid) begin
      dly[0] <= x_in;
      for (int k = 1; k < TAPS-1; k++) dly[k] <= dly[k-1];
    end
  end

  assign win[0] = x_in;
  for (genvar k = 1; k < TAPS; k++) begin : g_win
    assign win[k] = dly[k-1];
  end

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    assign coef_flat[k*W +: W] = coef[k];
    for (genvar i = 0; i < W; i++) begin : g_xb
      for (genvar j = 0; j < W; j++) begin : g_cb
        for (genvar r = 0; r < REP; r++) begin : g_rep
          localparam int IX = ((k*W + i)*W + j)*REP + r;
          assign strm[IX] = (win[k][i] & coef[k][j]) ^ fault_mask[IX];
        end
      end
    end
  end

  for (genvar c = 0; c < COLS; c++) begin : g_col
    localparam int LO = (c >= W) ? c - W + 1 : 0;
    localparam int HI = (c < W) ? c : W - 1;
    logic [CW-1:0] cnt;

    for (genvar b = 0; b < BIAS; b++) begin : g_bias
      assign strm[DBITS + c*BIAS + b] = ~fault_mask[DBITS + c*BIAS + b];
    end

    always_comb begin
      cnt = '0;
      for (int k = 0; k < TAPS; k++)
        for (int i = LO; i <= HI; i++)
          for (int r = 0; r < REP; r++)
            cnt = cnt + CW'(strm[((k*W + i)*W + (c - i))*REP + r]);
      for (int b = 0; b < BIAS; b++)
        cnt = cnt + CW'(strm[DBITS + c*BIAS + b]);
    end

    assign ccnt[c*CW +: CW] = cnt;
  end

  always_comb begin
    ysum = '0;
    for (int c = 0; c < COLS; c++)
      ysum = ysum + (YW'(ccnt[c*CW +: CW] / CW'(REP)) << c);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fill      <= '0;
      out_valid <= 1'b0;
      y         <= '0;
    end else begin
      out_valid <= in_valid && full;
      if (in_valid && !full) fill <= fill + 1'b1;
      if (in_valid && full)  y <= ysum;
    end
  end
endmodule

// File: rtl/stream_fir_chk.sv
module stream_fir_chk #(
  parameter int W    = 8,
  parameter int TAPS = 5,
  parameter int AW   = 3,
  parameter int YW   = 19
) (
  input logic              clk,
  input logic              rst,
  input logic              coef_we,
  input logic [AW-1:0]     coef_addr,
  input logic              in_valid,
  input logic              out_valid,
  input logic [YW-1:0]     y,
  input logic [TAPS*W-1:0] coef_flat
);
  logic       armed;
  logic [7:0] seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      seen  <= '0;
    end else begin
      armed <= 1'b1;
      if (in_valid && seen < 8'(TAPS)) seen <= seen + 8'd1;
    end
  end

  p_valid_after_input_r4: assert property (@(posedge clk) disable iff (rst)
    armed && out_valid |-> $past(in_valid));

  p_fill_before_valid_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> seen >= 8'(TAPS));

  p_hold_when_idle_r5: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(in_valid) |-> $stable(y) && !out_valid);

  p_coef_ignore_r2: assert property (@(posedge clk) disable iff (rst)
    coef_we && ({1'b0, coef_addr} >= (AW+1)'(TAPS)) |=> $stable(coef_flat));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> 32'(y) <= TAPS*(2**W-1)*(2**W-1));

  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> !out_valid && y == '0);
endmodule

bind stream_fir stream_fir_chk #(.W(W), .TAPS(TAPS), .AW(AW), .YW(YW)) u_chk (
  .clk(clk), .rst(rst), .coef_we(coef_we), .coef_addr(coef_addr),
  .in_valid(in_valid), .out_valid(out_valid), .y(y), .coef_flat(coef_flat)
);

// File: tb/stream_fir_tb.sv
module stream_fir_tb;
  localparam int W = 8, TAPS = 5, REP = 8, BIAS = 4, COLS = 15;
  localparam int DBITS = TAPS*W*W*REP;
  localparam int FLAT = DBITS + COLS*BIAS;
  localparam int NV = 10;
  localparam logic [7:0] TX [NV] = '{8'd10, 8'd20, 8'd30, 8'd40, 8'd50,
                                     8'd0, 8'd0, 8'd0, 8'd0, 8'd255};
  localparam int TEXP [NV] = '{-1, -1, -1, -1, 350, 440, 460, 400, 250, 255};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic coef_we = 1'b0;
  logic [2:0] coef_addr = '0;
  logic [7:0] coef_data = '0;
  logic in_valid = 1'b0;
  logic [7:0] x_in = '0;
  logic [FLAT-1:0] fault_mask = '0;
  logic out_valid;
  logic [18:0] y;

  int compared = 0, mismatched = 0;
  int mcoef [TAPS];
  int hist [TAPS];
  int nsamp = 0;
  int last_y = 0;

  always #5 clk = ~clk;

  stream_fir u_dut (
    .clk(clk), .rst(rst), .coef_we(coef_we), .coef_addr(coef_addr),
    .coef_data(coef_data), .in_valid(in_valid), .x_in(x_in),
    .fault_mask(fault_mask), .out_valid(out_valid), .y(y)
  );

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int didx(int k, int i, int j, int r);
    return ((k*W + i)*W + j)*REP + r;
  endfunction

  function automatic logic [FLAT-1:0] rand_mask(int maxf, bit bias_only);
    logic [FLAT-1:0] m = '0;
    for (int c = 0; c < COLS; c++) begin
      int n = int'($urandom % 32'(maxf + 1));
      for (int f = 0; f < n; f++) begin
        if (bias_only || ($urandom % 8) == 0) begin
          m[DBITS + c*BIAS + int'($urandom % 4)] = 1'b1;
        end else begin
          int lo = (c >= W) ? c - W + 1 : 0;
          int hi = (c < W) ? c : W - 1;
          int i = lo + int'($urandom % 32'(hi - lo + 1));
          m[didx(int'($urandom % 5), i, c - i, int'($urandom % 8))] = 1'b1;
        end
      end
    end
    return m;
  endfunction

  function automatic logic [FLAT-1:0] worst_mask();
    logic [FLAT-1:0] m = '0;
    for (int c = 0; c < COLS; c++) begin
      int i = (c >= W) ? c - W + 1 : 0;
      for (int r = 0; r < 3; r++) m[didx(0, i, c - i, r)] = 1'b1;
    end
    return m;
  endfunction

  function automatic int model_y();
    int s = 0;
    for (int k = 0; k < TAPS; k++) s += mcoef[k] * hist[k];
    return s;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 out_valid in reset", int'(out_valid), 0);
    check("R1 y in reset", int'(y), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 out_valid after reset", int'(out_valid), 0);
    check("R1 y after reset", int'(y), 0);
    for (int k = 0; k < TAPS; k++) begin mcoef[k] = 0; hist[k] = 0; end
    nsamp = 0;
    last_y = 0;
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    coef_we = 1'b1; coef_addr = 3'(a); coef_data = 8'(d);
    @(negedge clk);
    coef_we = 1'b0;
    if (a < TAPS) mcoef[a] = d;
  endtask

  task automatic step(input int x, input logic [FLAT-1:0] m, input string req);
    @(negedge clk);
    in_valid = 1'b1; x_in = 8'(x); fault_mask = m;
    @(negedge clk);
    in_valid = 1'b0; fault_mask = '0;
    for (int k = TAPS-1; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = x;
    nsamp++;
    check({req, " out_valid"}, int'(out_valid), (nsamp >= TAPS) ? 1 : 0);
    if (nsamp >= TAPS) begin
      last_y = model_y();
      check({req, " y"}, int'(y), last_y);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    do_reset();

    // R2: addresses 0..4 load taps, 5..7 must be ignored
    for (int a = 0; a < TAPS; a++) wr(a, a + 1);
    wr(5, 77); wr(6, 200); wr(7, 255);

    // table walk: R3 values, R4 fill
    for (int n = 0; n < NV; n++) begin
      @(negedge clk);
      in_valid = 1'b1; x_in = TX[n];
      @(negedge clk);
      in_valid = 1'b0;
      for (int k = TAPS-1; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = int'(TX[n]);
      nsamp++;
      check("R4 table out_valid", int'(out_valid), (TEXP[n] >= 0) ? 1 : 0);
      if (TEXP[n] >= 0) check("R3/R2 table y", int'(y), TEXP[n]);
    end
    last_y = 255;

    // R5: idle cycles with garbage masks
    for (int t = 0; t < 4; t++) begin
      @(negedge clk);
      fault_mask = rand_mask(7, 1'b0);
      @(negedge clk);
      check("R5 idle out_valid", int'(out_valid), 0);
      check("R5 idle y hold", int'(y), last_y);
    end
    fault_mask = '0;

    // R2 directed: writes to 6 and 7 between samples change nothing
    wr(6, 9); wr(7, 1);
    step(3, '0, "R2 ignored write");

    // R6: random data and coefficients with up to three flips per column
    for (int t = 0; t < 60; t++) begin
      if (t % 7 == 0) wr(int'($urandom % 5), int'($urandom % 256));
      step(int'($urandom % 256), rand_mask(3, 1'b0), "R6 random faults");
    end

    // R7: bias-only flips
    for (int t = 0; t < 10; t++)
      step(int'($urandom % 256), rand_mask(3, 1'b1), "R7 bias flips");

    // R8 with R6 ones-to-zeros worst case
    for (int a = 0; a < TAPS; a++) wr(a, 255);
    for (int t = 0; t < TAPS; t++) step(255, worst_mask(), "R8 full scale");
    check("R8 full-scale value", int'(y), 325125);

    // R6 zeros-to-ones worst case
    for (int t = 0; t < TAPS; t++) step(0, worst_mask(), "R6 zero flips");
    check("R6 zero result", int'(y), 0);

    // R1/R4: mid-run reset, refill
    do_reset();
    for (int a = 0; a < TAPS; a++) wr(a, 17 * (a + 2));
    for (int t = 0; t < 7; t++) step(int'($urandom % 256), rand_mask(3, 1'b0), "R4 refill");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule